// File: doc/BRIEF.md
# Frame-Synchronous SPI Game Parameter Bank

This block receives game-control commands for a paddle-and-ball video game over a write-only SPI link (mode 0) and turns them into the live parameters the game logic reads. These parameters are paddle position, paddle size, ball size, ball velocity and a pause flag. Each completed command lands in a shadow store first. The live values are loaded from that store only on the system clock edge where the frame-start strobe is high, so the picture never changes in the middle of a frame.

The block also holds the paddle position. The up and down buttons step it by one on each frame. This works whether or not a position was written over SPI, and the result is always clamped to the playfield. If the SPI pins stay idle after reset, the game runs on built-in default values. The SPI pins are asynchronous to the system clock and pass through a two-flop synchroniser. Frame start and the buttons are assumed to be synchronous to the system clock already.

Top module: `game_param_spi`

## Requirements
- R1: After reset, with default parameters, the outputs are paddle position 200, paddle size 48, ball size 8, ball velocity 8'h22 (x = +2 in bits 3:0, y = +2 in bits 7:4) and pause 0.
- R2: A command is 16 bits, MSB first, sampled on rising SPI clock edges while chip select (active low) is low. Bits 15:12 are the register address and bits 11:0 are the value.
- R3: The outputs change only on the clock edge where frame_start is high. In any cycle that follows a cycle with frame_start low, every output holds its value.
- R4: A completed command takes effect at the next frame_start. Until then, the outputs keep their old values.
- R5: The address map is as follows. 1 sets the paddle position. 2 sets the paddle size (value bits 5:0). 3 sets the ball size (value bits 4:0). 4 sets the velocity (x = value bits 3:0, y = value bits 7:4, two's complement). 5 sets pause from value bit 0. Addresses 0 and 6 to 15 change nothing.
- R6: If chip select goes high before the 16th bit, the partial command is discarded, and the next command starts again from bit 15.
- R7: At each frame_start, up alone lowers the paddle position by one and down alone raises it by one. Both buttons pressed, or neither, leave it unchanged.
- R8: When a position command is pending at a frame_start, the pending value is loaded first and the button step is then applied to it.
- R9: The paddle position is always clamped to the playfield range [8, 440]. This holds for SPI values and for button steps alike.
- R10: A pending command is used at one frame only. Later frames step from the live position and do not go back to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sclk | input | 1 | SPI clock, asynchronous |
| spi_mosi | input | 1 | SPI data in |
| spi_csn | input | 1 | SPI chip select, active low |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| btn_up | input | 1 | Step paddle position down by one per frame |
| btn_down | input | 1 | Step paddle position up by one per frame |
| paddle_pos | output | 10 | Live paddle position |
| paddle_size | output | 6 | Live paddle size |
| ball_size | output | 5 | Live ball size |
| ball_vel | output | 8 | Live ball velocity {y, x} |
| paused | output | 1 | Live pause flag |

## Verification
The bench builds the block with its default parameters and with chip select in use. A 10-bit position combined with limits of 8 and 440 puts both clamp edges within reach: a single 12-bit write can overshoot the upper limit, and a few button frames can push against the lower one. The SPI clock runs at one eighth of the system clock. Its edges therefore cross the synchroniser cleanly, which lets the bench time an abort partway through a command and a write that lands just before a frame.

// File: rtl/game_param_pkg.sv
package game_param_pkg;
   localparam int CMD_W  = 16;
   localparam int ADDR_W = 4;
   localparam int VAL_W  = 12;
   localparam int NREG   = 5;

   typedef enum logic [ADDR_W-1:0] {
      RA_POS   = 4'd1,
      RA_PSIZE = 4'd2,
      RA_BALL  = 4'd3,
      RA_VEL   = 4'd4,
      RA_PAUSE = 4'd5
   } reg_addr_e;

   function automatic int reg_index(input logic [ADDR_W-1:0] a);
      return int'(a) - 1;
   endfunction
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
   parameter int W = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= RST_VAL;
         q    <= RST_VAL;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/gp_spi_rx.sv
module gp_spi_rx
   import game_param_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_s,
   input  logic             mosi_s,
   input  logic             csn_s,
   output logic             wr_stb,
   output logic [CMD_W-1:0] wr_word
);
   localparam int CNT_W = $clog2(CMD_W);

   logic             sclk_q;
   logic             sclk_rise;
   logic [CNT_W-1:0] bit_cnt;
   logic [CMD_W-2:0] shreg;

   assign sclk_rise = sclk_s & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         wr_stb  <= 1'b0;
         wr_word <= '0;
      end else begin
         sclk_q <= sclk_s;
         wr_stb <= 1'b0;
         if (csn_s) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            shreg <= {shreg[CMD_W-3:0], mosi_s};
            if (bit_cnt == CNT_W'(CMD_W-1)) begin
               bit_cnt <= '0;
               wr_stb  <= 1'b1;
               wr_word <= {shreg, mosi_s};
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/gp_shadow.sv
module gp_shadow
   import game_param_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [CMD_W-1:0]  wr_word,
   input  logic              frame_start,
   output logic [VAL_W-1:0]  shadow [NREG],
   output logic [NREG-1:0]   pend
);
   logic [ADDR_W-1:0] addr;
   logic [VAL_W-1:0]  val;

   assign addr = wr_word[CMD_W-1:VAL_W];
   assign val  = wr_word[VAL_W-1:0];

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic hit;
      assign hit = wr_stb && (reg_index(addr) == i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow[i] <= '0;
            pend[i]   <= 1'b0;
         end else begin
            if (hit) shadow[i] <= val;
            // a write in the frame cycle stays pending for the next frame
            pend[i] <= hit | (pend[i] & ~frame_start);
         end
      end
   end
endmodule

// File: rtl/game_param_spi.sv
module game_param_spi
   import game_param_pkg::*;
#(
   parameter int POS_W      = 10,
   parameter int PSIZE_W    = 6,
   parameter int BALL_W     = 5,
   parameter int VEL_W      = 4,
   parameter int POS_MIN    = 8,
   parameter int POS_MAX    = 440,
   parameter int POS_RST    = 200,
   parameter int PSIZE_RST  = 48,
   parameter int BALL_RST   = 8,
   parameter int VEL_RST    = 8'h22,
   parameter bit USE_CS     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_sclk,
   input  logic               spi_mosi,
   input  logic               spi_csn,
   input  logic               frame_start,
   input  logic               btn_up,
   input  logic               btn_down,
   output logic [POS_W-1:0]   paddle_pos,
   output logic [PSIZE_W-1:0] paddle_size,
   output logic [BALL_W-1:0]  ball_size,
   output logic [2*VEL_W-1:0] ball_vel,
   output logic               paused
);
   localparam int SW = VAL_W + 2;

   if (POS_MIN >= POS_MAX || POS_MAX >= (1 << POS_W))
      $error("game_param_spi: bad position limits");
   if (POS_RST < POS_MIN || POS_RST > POS_MAX)
      $error("game_param_spi: reset position outside limits");
   if (POS_W > VAL_W || PSIZE_W > VAL_W || BALL_W > VAL_W || 2*VEL_W > VAL_W)
      $error("game_param_spi: field wider than command value");

   logic             sclk_s, mosi_s, csn_s, csn_raw;
   logic             wr_stb;
   logic [CMD_W-1:0] wr_word;
   logic [VAL_W-1:0] shadow [NREG];
   logic [NREG-1:0]  pend;
   logic             pos_pend;

   if (USE_CS) begin : g_cs
      assign csn_raw = spi_csn;
   end else begin : g_no_cs
      assign csn_raw = 1'b0;
   end

   gp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({csn_raw, spi_sclk, spi_mosi}),
      .q({csn_s, sclk_s, mosi_s})
   );

   gp_spi_rx u_rx (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sclk_s), .mosi_s(mosi_s), .csn_s(csn_s),
      .wr_stb(wr_stb), .wr_word(wr_word)
   );

   gp_shadow u_shadow (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_stb), .wr_word(wr_word),
      .frame_start(frame_start),
      .shadow(shadow), .pend(pend)
   );

   assign pos_pend = pend[reg_index(RA_POS)];

   // position: pending value first, then the button step, then clamp
   logic signed [SW-1:0] pos_base, pos_step, pos_next;

   always_comb begin
      pos_base = pos_pend ? SW'(shadow[reg_index(RA_POS)])
                          : SW'(paddle_pos);
      pos_step = pos_base;
      if (btn_up && !btn_down)      pos_step = pos_base - SW'(1);
      else if (btn_down && !btn_up) pos_step = pos_base + SW'(1);
      if (pos_step < SW'(POS_MIN))      pos_next = SW'(POS_MIN);
      else if (pos_step > SW'(POS_MAX)) pos_next = SW'(POS_MAX);
      else                              pos_next = pos_step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paddle_pos  <= POS_W'(POS_RST);
         paddle_size <= PSIZE_W'(PSIZE_RST);
         ball_size   <= BALL_W'(BALL_RST);
         ball_vel    <= (2*VEL_W)'(VEL_RST);
         paused      <= 1'b0;
      end else if (frame_start) begin
         paddle_pos <= POS_W'(pos_next);
         if (pend[reg_index(RA_PSIZE)])
            paddle_size <= shadow[reg_index(RA_PSIZE)][PSIZE_W-1:0];
         if (pend[reg_index(RA_BALL)])
            ball_size <= shadow[reg_index(RA_BALL)][BALL_W-1:0];
         if (pend[reg_index(RA_VEL)])
            ball_vel <= shadow[reg_index(RA_VEL)][2*VEL_W-1:0];
         if (pend[reg_index(RA_PAUSE)])
            paused <= shadow[reg_index(RA_PAUSE)][0];
      end
   end
endmodule

// File: rtl/game_param_chk.sv
module game_param_chk #(
   parameter int POS_W   = 10,
   parameter int PSIZE_W = 6,
   parameter int BALL_W  = 5,
   parameter int VEL_W   = 4,
   parameter int POS_MIN = 8,
   parameter int POS_MAX = 440
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_start,
   input logic               btn_up,
   input logic               btn_down,
   input logic               pos_pend,
   input logic [POS_W-1:0]   paddle_pos,
   input logic [PSIZE_W-1:0] paddle_size,
   input logic [BALL_W-1:0]  ball_size,
   input logic [2*VEL_W-1:0] ball_vel,
   input logic               paused
);
   AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(paddle_pos) && $stable(paddle_size) && $stable(ball_size)
                        && $stable(ball_vel) && $stable(paused))); // R3

   AST_POS_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (paddle_pos >= POS_W'(POS_MIN)) && (paddle_pos <= POS_W'(POS_MAX))); // R9

   AST_UP_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !pos_pend && btn_up && !btn_down && paddle_pos > POS_W'(POS_MIN))
      |=> paddle_pos == $past(paddle_pos) - 1'b1); // R7

   AST_NO_STEP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !pos_pend && btn_up && btn_down) |=> $stable(paddle_pos)); // R7

   AST_LIVE_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !pos_pend) |=> (paddle_pos == $past(paddle_pos)
         || paddle_pos == $past(paddle_pos) + 1'b1
         || paddle_pos == $past(paddle_pos) - 1'b1)); // R10
endmodule

bind game_param_spi game_param_chk #(
   .POS_W(POS_W), .PSIZE_W(PSIZE_W), .BALL_W(BALL_W), .VEL_W(VEL_W),
   .POS_MIN(POS_MIN), .POS_MAX(POS_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
   .btn_up(btn_up), .btn_down(btn_down), .pos_pend(pos_pend),
   .paddle_pos(paddle_pos), .paddle_size(paddle_size), .ball_size(ball_size),
   .ball_vel(ball_vel), .paused(paused)
);

// File: tb/game_param_spi_bench.sv
module game_param_spi_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
   logic frame = 1'b0, up = 1'b0, down = 1'b0;
   logic [9:0] pos;
   logic [5:0] psize;
   logic [4:0] bsize;
   logic [7:0] vel;
   logic       pause;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   game_param_spi u_game_param_spi (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_csn(csn),
      .frame_start(frame), .btn_up(up), .btn_down(down),
      .paddle_pos(pos), .paddle_size(psize), .ball_size(bsize),
      .ball_vel(vel), .paused(pause)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // send nbits of {addr,val} MSB first; csn released afterwards
   task automatic spi_send(input logic [3:0] addr, input logic [11:0] val, input int nbits);
      logic [15:0] w;
      w = {addr, val};
      @(negedge clk) csn = 1'b0;
      wait_clk(4);
      for (int i = 15; i > 15 - nbits; i--) begin
         mosi = w[i];
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
      wait_clk(4);
      csn = 1'b1;
      wait_clk(8);
   endtask

   task automatic frame_tick(input logic u, input logic d);
      @(negedge clk);
      up = u; down = d; frame = 1'b1;
      @(negedge clk);
      frame = 1'b0; up = 1'b0; down = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 pos", pos, 200);
      chk("R1 psize", psize, 48);
      chk("R1 ball", bsize, 8);
      chk("R1 vel", vel, 8'h22);
      chk("R1 pause", pause, 0);
      frame_tick(0, 0);
      chk("R1 free-run pos", pos, 200);
   endtask

   task automatic t_buffered;
      spi_send(4'd2, 12'd20, 16);
      chk("R4 psize before frame", psize, 48);
      frame_tick(0, 0);
      chk("R2 R4 psize after frame", psize, 20);
   endtask

   task automatic t_map;
      spi_send(4'd3, 12'd5, 16);
      spi_send(4'd4, 12'h0F1, 16);
      spi_send(4'd5, 12'd1, 16);
      chk("R3 no change without frame", bsize, 8);
      frame_tick(0, 0);
      chk("R5 ball", bsize, 5);
      chk("R5 vel", vel, 8'hF1);
      chk("R5 pause set", pause, 1);
      spi_send(4'd5, 12'd0, 16);
      frame_tick(0, 0);
      chk("R5 pause clear", pause, 0);
      spi_send(4'd0, 12'd99, 16);
      spi_send(4'd15, 12'd99, 16);
      frame_tick(0, 0);
      chk("R5 unknown addr pos", pos, 200);
      chk("R5 unknown addr psize", psize, 20);
      chk("R5 unknown addr ball", bsize, 5);
   endtask

   task automatic t_abort;
      spi_send(4'd2, 12'd33, 9);
      frame_tick(0, 0);
      chk("R6 aborted psize", psize, 20);
      spi_send(4'd2, 12'd33, 16);
      frame_tick(0, 0);
      chk("R6 restart after abort", psize, 33);
   endtask

   task automatic t_buttons;
      frame_tick(1, 0);
      chk("R7 up", pos, 199);
      frame_tick(0, 1);
      frame_tick(0, 1);
      chk("R7 down twice", pos, 201);
      frame_tick(1, 1);
      chk("R7 both", pos, 201);
   endtask

   task automatic t_pos_write;
      spi_send(4'd1, 12'd100, 16);
      frame_tick(0, 1);
      chk("R8 load then step", pos, 101);
      frame_tick(0, 1);
      chk("R10 step from live", pos, 102);
      frame_tick(0, 0);
      chk("R10 no reload", pos, 102);
   endtask

   task automatic t_clamp;
      spi_send(4'd1, 12'd4095, 16);
      frame_tick(0, 1);
      chk("R9 upper clamp", pos, 440);
      spi_send(4'd1, 12'd9, 16);
      frame_tick(1, 0);
      chk("R9 write then up", pos, 8);
      frame_tick(1, 0);
      chk("R9 lower clamp", pos, 8);
      spi_send(4'd1, 12'd0, 16);
      frame_tick(0, 0);
      chk("R9 zero write clamped", pos, 8);
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
      t_reset();
      t_buffered();
      t_map();
      t_abort();
      t_buttons();
      t_pos_write();
      t_clamp();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule